// File: doc/BRIEF.md
# Four-Channel DMA Transfer Sequencer

This block sequences unit transfers for four DMA channels. Each channel holds a current and a base address, a current and a base count, and a mode byte. A shared mask register and a shared command register sit beside them. Software programs the channels through a simple register write port. Each request input and end-of-transfer input belongs to one channel. For every unit the sequencer moves, it steps that channel's address and counts its count down. Depending on the transfer mode, it then decides whether the transfer has ended. At the end it either reloads the channel from its base registers or masks the channel. Each channel drives a terminal-count output and an upper-byte-enable output.

The sequencer does not run the memory or I/O bus cycles itself. Each unit is offered on a valid/ready stream: `xfer_valid` carries the channel, address, width and direction.
- Once `xfer_valid` is raised, it stays high and all unit fields stay stable until a cycle in which `xfer_ready` is high. The unit completes in that cycle. The downstream side may hold `xfer_ready` low for any number of cycles; this is its back-pressure.
- The one exception is a software reset, which withdraws a unit that is in flight.
- Only one unit is in flight at a time. At least one idle cycle separates two units.
- When several channels are eligible, the lowest-numbered one wins.

Top module: `dmaseq_top`

## Requirements
- R1: After `rst_n` is released, all four channels are masked, the controller is enabled, `tc` and `ube` are 0 and `xfer_valid` is 0. A request edge on a channel in this state produces no unit.
- R2: The register port uses `cfg_sel` to pick a register. Value 0 writes the channel's base and current address. Value 1 writes its base and current count. Value 2 writes its mode byte. Value 3 writes the shared mask, with bit c set meaning channel c is masked. Value 4 writes the command. `cfg_ch` picks the channel for values 0 to 2.
- R3: `xfer_valid` holds with stable fields until `xfer_ready` is high. Among eligible channels, channel 0 has the highest priority and channel 3 the lowest, and the choice is made again for every unit.
- R4: After each unit the address steps by 2 for a word unit and by 1 for a byte unit. Mode bit 5 set means the address decrements; clear means it increments.
- R5: A channel moves words only when all three hold: mode bit 0 is set, `bus16_en` is high, and the current address is even. `ube[c]` shows this decision. The decision is recomputed when the channel becomes active, and when its address or mode is written while it is active.
- R6: The count is exhausted when it is 0 before the decrement, so a programmed count N moves N+1 units.
- R7: Mode bits 7:6 equal to 01 select single mode. In single mode each rising request edge moves one unit. `tc` is raised only on exhaustion, and end-of-transfer pulses have no effect.
- R8: Mode bits 7:6 equal to 00 select demand mode. The transfer ends at a unit whose completion cycle sees any of these: the request low, an unserved end-of-transfer latch, or exhaustion.
- R9: Mode bits 7:6 equal to 10 select block mode. A request that falls partway through does not end the transfer. Only exhaustion or an unserved end-of-transfer latch ends it.
- R10: At the end of a transfer the channel clears its pending request and sets `tc[c]`. If mode bit 4 (auto-initialise) is set, it reloads address and count from the base registers and stays unmasked. Otherwise it sets its mask bit and its later requests are ignored.
- R11: An `eot[c]` pulse is latched. The latch ends at most one transfer, because a served flag blocks it afterwards. A count write clears the latch, the served flag and `tc[c]`.
- R12: A command write with bit 0 set is a software reset: it masks all channels, clears pending requests, end latches, `tc` and `ube`, and withdraws an in-flight unit. Command bit 2 set disables the controller: no unit starts and request edges are not latched.
- R13: A request edge on a masked channel is not latched and produces no unit, even after the channel is later unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (see R2) |
| cfg_ch | input | 2 | Channel for per-channel registers |
| cfg_wdata | input | 24 | Write data |
| bus16_en | input | 1 | Global 16-bit bus option |
| dreq | input | 4 | Per-channel request levels |
| eot | input | 4 | Per-channel end-of-transfer pulses |
| xfer_valid | output | 1 | A unit is offered |
| xfer_ready | input | 1 | The unit completes this cycle |
| xfer_ch | output | 2 | Channel of the offered unit |
| xfer_addr | output | 24 | Address of the offered unit |
| xfer_word | output | 1 | 1 for a word unit, 0 for a byte unit |
| xfer_dir | output | 2 | Mode bits 3:2 of the channel (00 verify, 01 I/O to memory, 10 memory to I/O) |
| tc | output | 4 | Per-channel terminal count |
| ube | output | 4 | Per-channel upper-byte enable |

## Verification
A wrong address register or step shows up on `xfer_addr` at the next unit that channel offers. It is compared there against an independently computed sequence. A wrong count or a wrong end decision shows up within one transfer, as one unit too many or too few, with `tc` rising in the wrong place. A wrong width decision appears on `ube` in the cycle after the activating write. Mistakes in the mask, disable and end-latch state surface as an unexpected unit after a request edge, or as a transfer that ends early.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  typedef enum logic [1:0] {
    XM_DEMAND  = 2'b00,
    XM_SINGLE  = 2'b01,
    XM_BLOCK   = 2'b10,
    XM_CASCADE = 2'b11
  } xmode_e;

  typedef enum logic [2:0] {
    RS_ADDR  = 3'd0,
    RS_COUNT = 3'd1,
    RS_MODE  = 3'd2,
    RS_MASK  = 3'd3,
    RS_CMD   = 3'd4
  } rsel_e;

  // Word units need the mode word bit, the bus option and an even address.
  function automatic logic word_ok(input logic wbit, input logic bus16, input logic a0);
    return wbit & bus16 & ~a0;
  endfunction

endpackage

// File: rtl/dmaseq_prio.sv
module dmaseq_prio #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/dmaseq_chan.sv
module dmaseq_chan
  import dmaseq_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          wr_addr,
  input  logic          wr_count,
  input  logic          wr_mode,
  input  logic [AW-1:0] wdata,
  input  logic          active,
  input  logic          bus16,
  input  logic          dreq,
  input  logic          eot,
  input  logic          done,
  output logic [AW-1:0] cur_addr,
  output logic [1:0]    dir,
  output logic          wide,
  output logic          pend,
  output logic          tc,
  output logic          mask_req
);
  logic [AW-1:0] base_a;
  logic [CW-1:0] base_c, cur_c;
  xmode_e        xm;
  logic          dec_r, auto_r, wbit_r;
  logic          dreq_q, act_q, end_req, end_stat;
  logic          exhausted, eot_hit, finish;
  logic [AW-1:0] step, next_a;

  assign exhausted = (cur_c == '0);
  assign eot_hit   = end_req & ~end_stat & ((xm == XM_DEMAND) | (xm == XM_BLOCK));

  always_comb begin
    case (xm)
      XM_DEMAND: finish = exhausted | eot_hit | ~dreq;
      XM_BLOCK:  finish = exhausted | eot_hit;
      default:   finish = exhausted;
    endcase
  end

  assign step     = wide ? AW'(2) : AW'(1);
  assign next_a   = dec_r ? (cur_addr - step) : (cur_addr + step);
  assign mask_req = done & finish & ~auto_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_a   <= '0;
      cur_addr <= '0;
      base_c   <= '0;
      cur_c    <= '0;
      xm       <= XM_DEMAND;
      dec_r    <= 1'b0;
      auto_r   <= 1'b0;
      dir      <= 2'b00;
      wbit_r   <= 1'b0;
      dreq_q   <= 1'b0;
      act_q    <= 1'b0;
      end_req  <= 1'b0;
      end_stat <= 1'b0;
      pend     <= 1'b0;
      tc       <= 1'b0;
      wide     <= 1'b0;
    end else begin
      dreq_q <= dreq;
      act_q  <= active;
      if (soft_rst) begin
        end_req  <= 1'b0;
        end_stat <= 1'b0;
        pend     <= 1'b0;
        tc       <= 1'b0;
        wide     <= 1'b0;
      end else begin
        if (eot) end_req <= 1'b1;
        if (done) begin
          cur_addr <= next_a;
          cur_c    <= cur_c - CW'(1);
          if (xm != XM_DEMAND && xm != XM_BLOCK) pend <= 1'b0;
          if (eot_hit) end_stat <= 1'b1;
          if (finish) begin
            pend <= 1'b0;
            tc   <= 1'b1;
            if (auto_r) begin
              cur_addr <= base_a;
              cur_c    <= base_c;
            end
          end
        end
        if (active && dreq && !dreq_q) pend <= 1'b1;
        if (active && !act_q) wide <= word_ok(wbit_r, bus16, cur_addr[0]);
        if (wr_addr) begin
          base_a   <= wdata;
          cur_addr <= wdata;
          if (active) wide <= word_ok(wbit_r, bus16, wdata[0]);
        end
        if (wr_count) begin
          base_c   <= wdata[CW-1:0];
          cur_c    <= wdata[CW-1:0];
          end_req  <= 1'b0;
          end_stat <= 1'b0;
          tc       <= 1'b0;
        end
        if (wr_mode) begin
          xm     <= xmode_e'(wdata[7:6]);
          dec_r  <= wdata[5];
          auto_r <= wdata[4];
          dir    <= wdata[3:2];
          wbit_r <= wdata[0];
          if (active) wide <= word_ok(wdata[0], bus16, cur_addr[0]);
        end
      end
    end
  end
endmodule

// File: rtl/dmaseq_unit.sv
module dmaseq_unit #(
  parameter int NCH = 4,
  parameter int AW  = 24,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    soft_rst,
  input  logic [NCH-1:0]          elig,
  input  logic [NCH-1:0][AW-1:0]  addr_v,
  input  logic [NCH-1:0][1:0]     dir_v,
  input  logic [NCH-1:0]          wide_v,
  input  logic                    xfer_ready,
  output logic                    xfer_valid,
  output logic [CHW-1:0]          xfer_ch,
  output logic [AW-1:0]           xfer_addr,
  output logic                    xfer_word,
  output logic [1:0]              xfer_dir,
  output logic [NCH-1:0]          done
);
  logic [CHW-1:0] pick;
  logic           any;

  dmaseq_prio #(.N(NCH)) u_prio (
    .req (elig),
    .idx (pick),
    .any (any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_valid <= 1'b0;
      xfer_ch    <= '0;
      xfer_addr  <= '0;
      xfer_word  <= 1'b0;
      xfer_dir   <= 2'b00;
    end else if (soft_rst) begin
      xfer_valid <= 1'b0;
    end else if (xfer_valid) begin
      if (xfer_ready) xfer_valid <= 1'b0;
    end else if (any) begin
      xfer_valid <= 1'b1;
      xfer_ch    <= pick;
      xfer_addr  <= addr_v[pick];
      xfer_word  <= wide_v[pick];
      xfer_dir   <= dir_v[pick];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_done
    assign done[i] = xfer_valid && xfer_ready && !soft_rst && (xfer_ch == CHW'(i));
  end
endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top
  import dmaseq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 24,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [2:0]     cfg_sel,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic           bus16_en,
  input  logic [NCH-1:0] dreq,
  input  logic [NCH-1:0] eot,
  output logic           xfer_valid,
  input  logic           xfer_ready,
  output logic [CHW-1:0] xfer_ch,
  output logic [AW-1:0]  xfer_addr,
  output logic           xfer_word,
  output logic [1:0]     xfer_dir,
  output logic [NCH-1:0] tc,
  output logic [NCH-1:0] ube
);
  logic [NCH-1:0]         mask_r, mask_req_v, active, pend_v, done_v, wide_v;
  logic [NCH-1:0][AW-1:0] addr_v;
  logic [NCH-1:0][1:0]    dir_v;
  logic                   cmd_dis, soft_rst, wr_mask, wr_cmd;

  assign wr_mask  = cfg_we && (cfg_sel == RS_MASK);
  assign wr_cmd   = cfg_we && (cfg_sel == RS_CMD);
  assign soft_rst = wr_cmd && cfg_wdata[0];
  assign active   = ~mask_r & {NCH{~cmd_dis}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_r  <= '1;
      cmd_dis <= 1'b0;
    end else begin
      mask_r <= mask_r | mask_req_v;
      if (wr_mask) mask_r <= cfg_wdata[NCH-1:0];
      if (wr_cmd) cmd_dis <= cfg_wdata[2];
      if (soft_rst) mask_r <= '1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_ch;
    assign sel_ch = cfg_we && (cfg_ch == CHW'(c));
    dmaseq_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .wr_addr  (sel_ch && (cfg_sel == RS_ADDR)),
      .wr_count (sel_ch && (cfg_sel == RS_COUNT)),
      .wr_mode  (sel_ch && (cfg_sel == RS_MODE)),
      .wdata    (cfg_wdata),
      .active   (active[c]),
      .bus16    (bus16_en),
      .dreq     (dreq[c]),
      .eot      (eot[c]),
      .done     (done_v[c]),
      .cur_addr (addr_v[c]),
      .dir      (dir_v[c]),
      .wide     (wide_v[c]),
      .pend     (pend_v[c]),
      .tc       (tc[c]),
      .mask_req (mask_req_v[c])
    );
  end

  dmaseq_unit #(.NCH(NCH), .AW(AW)) u_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .elig       (active & pend_v),
    .addr_v     (addr_v),
    .dir_v      (dir_v),
    .wide_v     (wide_v),
    .xfer_ready (xfer_ready),
    .xfer_valid (xfer_valid),
    .xfer_ch    (xfer_ch),
    .xfer_addr  (xfer_addr),
    .xfer_word  (xfer_word),
    .xfer_dir   (xfer_dir),
    .done       (done_v)
  );

  assign ube = wide_v;
endmodule

// File: rtl/dmaseq_chk.sv
module dmaseq_chk #(
  parameter int NCH = 4,
  parameter int AW  = 24,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           soft_rst,
  input logic           xfer_valid,
  input logic           xfer_ready,
  input logic [CHW-1:0] xfer_ch,
  input logic [AW-1:0]  xfer_addr,
  input logic           xfer_word,
  input logic [NCH-1:0] mask,
  input logic           dis,
  input logic [NCH-1:0] tc
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready && !soft_rst) |=>
      (xfer_valid && $stable(xfer_addr) && $stable(xfer_ch) && $stable(xfer_word)));

  assert_word_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_word |-> !xfer_addr[0]);

  assert_soft_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tc == '0 && !xfer_valid));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assert_launch_open_R13: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(xfer_valid) && xfer_ch == CHW'(i)) |-> $past(!mask[i] && !dis));

    assert_tc_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc[i]) |-> $past(xfer_valid && xfer_ready && xfer_ch == CHW'(i)));
  end
endmodule

bind dmaseq_top dmaseq_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .xfer_valid (xfer_valid),
  .xfer_ready (xfer_ready),
  .xfer_ch    (xfer_ch),
  .xfer_addr  (xfer_addr),
  .xfer_word  (xfer_word),
  .mask       (mask_r),
  .dis        (cmd_dis),
  .tc         (tc)
);

// File: tb/dmaseq_top_tb.sv
`timescale 1ns/1ps
module dmaseq_top_tb;
  import dmaseq_pkg::*;
  localparam int NCH = 4;
  localparam int AW  = 24;
  localparam int CW  = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_we = 1'b0;
  logic [2:0]     cfg_sel = '0;
  logic [1:0]     cfg_ch = '0;
  logic [AW-1:0]  cfg_wdata = '0;
  logic           bus16_en = 1'b0;
  logic [NCH-1:0] dreq = '0;
  logic [NCH-1:0] eot = '0;
  logic           rdy = 1'b1;
  logic           xfer_valid, xfer_word;
  logic [1:0]     xfer_ch, xfer_dir;
  logic [AW-1:0]  xfer_addr;
  logic [NCH-1:0] tc, ube;

  always #10 clk = ~clk;

  dmaseq_top #(.NCH(NCH), .AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_ch(cfg_ch),
    .cfg_wdata(cfg_wdata), .bus16_en(bus16_en), .dreq(dreq), .eot(eot),
    .xfer_valid(xfer_valid), .xfer_ready(rdy), .xfer_ch(xfer_ch),
    .xfer_addr(xfer_addr), .xfer_word(xfer_word), .xfer_dir(xfer_dir),
    .tc(tc), .ube(ube)
  );

  typedef struct {
    int            ch;
    logic [AW-1:0] addr;
    logic          word;
    string         req;
  } unit_t;

  unit_t exp_q[$];
  int    n_cmp = 0, n_bad = 0, hs_cnt = 0;
  string idle_req = "R1";

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Scoreboard monitor: samples 2 ns before each rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #8;
      if (rst_n && xfer_valid && rdy) begin
        hs_cnt++;
        if (exp_q.size() == 0) begin
          chk(idle_req, "unexpected unit on channel", xfer_ch, 99);
        end else begin
          unit_t e;
          e = exp_q.pop_front();
          chk(e.req, "unit channel", xfer_ch, e.ch);
          chk(e.req, "unit address", xfer_addr, e.addr);
          chk(e.req, "unit width", xfer_word, e.word);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic push(input int ch, input logic [AW-1:0] a, input logic w, input string req);
    unit_t e;
    e.ch = ch; e.addr = a; e.word = w; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wr(input rsel_e sel, input int ch, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_ch = 2'(ch); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_req(input int ch);
    @(negedge clk); dreq[ch] = 1'b1;
    @(negedge clk); dreq[ch] = 1'b0;
  endtask

  task automatic pulse_eot(input int ch);
    @(negedge clk); eot[ch] = 1'b1;
    @(negedge clk); eot[ch] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    chk(req, "units still missing", exp_q.size(), 0);
    exp_q.delete();
    idle(4);
  endtask

  initial begin
    int h0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1: reset state
    chk("R1", "tc after reset", tc, 0);
    chk("R1", "ube after reset", ube, 0);
    chk("R1", "valid after reset", xfer_valid, 0);
    idle_req = "R1";
    h0 = hs_cnt;
    pulse_req(0);
    idle(6);
    chk("R1", "units while all masked", hs_cnt - h0, 0);

    // R2 R4 R6 R9: block, byte, increment, count 3, request dropped at once
    idle_req = "R9";
    wr(RS_ADDR, 1, 24'h100);
    wr(RS_COUNT, 1, 24'd3);
    wr(RS_MODE, 1, 24'h84);
    wr(RS_MASK, 0, 24'hD);
    push(1, 24'h100, 1'b0, "R2");
    push(1, 24'h101, 1'b0, "R4");
    push(1, 24'h102, 1'b0, "R9");
    push(1, 24'h103, 1'b0, "R6");
    pulse_req(1);
    drain("R6");
    chk("R6", "tc after N+1 units", tc[1], 1);
    // R10: no auto-init, so channel is now masked
    idle_req = "R10";
    h0 = hs_cnt;
    pulse_req(1);
    idle(8);
    chk("R10", "units after masking end", hs_cnt - h0, 0);

    // R5 R8 R4: demand, word, decrement, request dropped mid-transfer
    bus16_en = 1'b1;
    idle_req = "R8";
    wr(RS_ADDR, 0, 24'h200);
    wr(RS_COUNT, 0, 24'd9);
    wr(RS_MODE, 0, 24'h29);
    wr(RS_MASK, 0, 24'hE);
    idle(3);
    chk("R5", "ube on word even channel", ube[0], 1);
    push(0, 24'h200, 1'b1, "R4");
    push(0, 24'h1FE, 1'b1, "R4");
    push(0, 24'h1FC, 1'b1, "R8");
    push(0, 24'h1FA, 1'b1, "R8");
    h0 = hs_cnt;
    @(negedge clk); dreq[0] = 1'b1;
    wait (hs_cnt == h0 + 3);
    @(negedge clk); rdy = 1'b0;
    @(negedge clk); dreq[0] = 1'b0;
    @(negedge clk); rdy = 1'b1;
    drain("R8");
    chk("R8", "tc after request drop", tc[0], 1);

    // R7 R5 R10: single, odd address, auto-init, count 1
    idle_req = "R7";
    wr(RS_ADDR, 3, 24'h301);
    wr(RS_COUNT, 3, 24'd1);
    wr(RS_MODE, 3, 24'h55);
    wr(RS_MASK, 0, 24'h7);
    idle(3);
    chk("R5", "ube on odd address", ube[3], 0);
    pulse_eot(3);
    push(3, 24'h301, 1'b0, "R7");
    pulse_req(3);
    drain("R7");
    chk("R7", "tc after one single unit", tc[3], 0);
    push(3, 24'h302, 1'b0, "R7");
    rdy = 1'b0;
    pulse_req(3);
    idle(3);
    chk("R3", "valid held under back-pressure", xfer_valid, 1);
    chk("R3", "address held under back-pressure", xfer_addr, 24'h302);
    rdy = 1'b1;
    drain("R7");
    chk("R7", "tc on single exhaustion", tc[3], 1);
    push(3, 24'h301, 1'b0, "R10");
    pulse_req(3);
    drain("R10");

    // R11 R3: count write clears tc; two block channels, fixed priority
    idle_req = "R3";
    wr(RS_COUNT, 0, 24'd1);
    chk("R11", "tc cleared by count write", tc[0], 0);
    wr(RS_ADDR, 0, 24'h400);
    wr(RS_MODE, 0, 24'h84);
    wr(RS_ADDR, 2, 24'h500);
    wr(RS_COUNT, 2, 24'd1);
    wr(RS_MODE, 2, 24'h84);
    wr(RS_MASK, 0, 24'h2);
    idle(3);
    chk("R5", "ube on byte mode channel", ube[0], 0);
    push(0, 24'h400, 1'b0, "R3");
    push(0, 24'h401, 1'b0, "R3");
    push(2, 24'h500, 1'b0, "R3");
    push(2, 24'h501, 1'b0, "R3");
    @(negedge clk); dreq[0] = 1'b1; dreq[2] = 1'b1;
    @(negedge clk); dreq[0] = 1'b0; dreq[2] = 1'b0;
    drain("R3");

    // R11 R10: block auto-init ended once by a latched end-of-transfer
    idle_req = "R11";
    wr(RS_ADDR, 1, 24'h600);
    wr(RS_COUNT, 1, 24'd2);
    chk("R11", "tc cleared by count write", tc[1], 0);
    wr(RS_MODE, 1, 24'h94);
    wr(RS_MASK, 0, 24'h5);
    rdy = 1'b0;
    push(1, 24'h600, 1'b0, "R11");
    pulse_req(1);
    idle(2);
    pulse_eot(1);
    rdy = 1'b1;
    drain("R11");
    chk("R11", "tc after end-of-transfer", tc[1], 1);
    push(1, 24'h600, 1'b0, "R10");
    push(1, 24'h601, 1'b0, "R11");
    push(1, 24'h602, 1'b0, "R11");
    pulse_req(1);
    drain("R11");

    // R5: width recomputed on writes while active
    wr(RS_ADDR, 3, 24'h700);
    chk("R5", "ube after even address write", ube[3], 1);
    wr(RS_MODE, 3, 24'h54);
    chk("R5", "ube after word bit cleared", ube[3], 0);
    wr(RS_MODE, 3, 24'h55);
    chk("R5", "ube after word bit set", ube[3], 1);
    bus16_en = 1'b0;
    wr(RS_ADDR, 3, 24'h702);
    chk("R5", "ube with bus option off", ube[3], 0);

    // R12: disable, then software reset
    idle_req = "R12";
    wr(RS_CMD, 0, 24'h4);
    h0 = hs_cnt;
    pulse_req(3);
    idle(6);
    chk("R12", "valid while disabled", xfer_valid, 0);
    wr(RS_CMD, 0, 24'h0);
    idle(6);
    chk("R12", "units from request seen while disabled", hs_cnt - h0, 0);
    rdy = 1'b0;
    pulse_req(3);
    idle(2);
    chk("R12", "unit offered before reset", xfer_valid, 1);
    wr(RS_CMD, 0, 24'h1);
    chk("R12", "valid withdrawn by soft reset", xfer_valid, 0);
    chk("R12", "tc after soft reset", tc, 0);
    chk("R12", "ube after soft reset", ube, 0);
    rdy = 1'b1;
    idle_req = "R13";
    h0 = hs_cnt;
    pulse_req(3);
    wr(RS_MASK, 0, 24'h7);
    idle(6);
    chk("R13", "request while masked not latched", hs_cnt - h0, 0);

    summary();
  end
endmodule